// File: doc/BRIEF.md
# Background Offset and Gain Equaliser for an Interleaved Converter

This block lines up the offset and gain of the N sub-converters of a time-interleaved converter while the sample stream keeps flowing. Each incoming sample carries the index of the unit that produced it. The block corrects the sample with that unit's offset and gain registers and passes it on one cycle later. Alongside this it gathers statistics on the corrected stream. For each unit it keeps the sum of the offset-removed codes and the sum of the absolute corrected codes.

Once every unit has delivered a full window of 2^K samples, the block compares each unit's mean with the average over the whole array. It then moves that unit's correction one small step in the direction that reduces the difference, so the array converges slowly over many windows. A foreground mode is meant for a shorted (zero) input. In this mode the window loads each unit's measured mean code straight into its offset register. Dropping the loop enable freezes both correction sets and discards any partly filled window. Correction of the live samples continues while the loop is paused.

Top module: `unit_match_eq`

## Requirements
- R1: After reset every offset register is 0, every gain register is 0x8000 (1.0 in unsigned Q1.15) and out_valid is low.
- R2: A sample with code x from unit u appears on the output exactly one cycle later with the same unit index and code floor((x - ofs[u]) * gain[u] / 2^15). The code is a two's complement value of CODE_W bits, and ofs_corr and gain_corr pack unit u at bit offset u*CODE_W and u*GAIN_W.
- R3: The corrected code saturates at +2^(CODE_W-1)-1 and at -2^(CODE_W-1).
- R4: A window closes once every unit has contributed 2^WIN_LOG2 samples. Further samples from a unit whose window share is already full do not affect the statistics.
- R5: In tracking mode (fg_mode low) each unit's floored mean of (x - ofs) is compared with the floored average of those means over all units. A larger mean raises the unit's offset by OFS_STEP, a smaller mean lowers it by OFS_STEP, and an equal mean leaves it unchanged. The offset is clamped to the code range.
- R6: In tracking mode each unit's floored mean of |corrected code| is compared with the floored array average of those means. A larger mean lowers the unit's gain by GAIN_STEP, a smaller mean raises it by GAIN_STEP, and the gain is clamped to 0..2^GAIN_W-1.
- R7: With fg_mode high at the close of a window, each offset register becomes the floored mean of that unit's raw codes over the window, and the gains do not change.
- R8: While loop_en is low, no correction register changes and no statistics are kept. A partly filled window is discarded, so the next window starts empty when loop_en rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loop_en | input | 1 | Runs the correction loop; low pauses it |
| fg_mode | input | 1 | High: window result loads offsets directly |
| in_valid | input | 1 | Input sample present |
| in_unit | input | $clog2(N_UNITS) | Index of the unit that produced the sample |
| in_code | input | CODE_W | Raw signed sample code |
| out_valid | output | 1 | Corrected sample present |
| out_unit | output | $clog2(N_UNITS) | Unit index of the corrected sample |
| out_code | output | CODE_W | Corrected, saturated signed code |
| ofs_corr | output | N_UNITS*CODE_W | Per-unit signed offset registers |
| gain_corr | output | N_UNITS*GAIN_W | Per-unit unsigned Q1.15 gain registers |

## Verification
Exhaustive code sweeps over every unit are run three times. The first runs at identity corrections, which shows a plain pass-through. The second runs after a foreground load that puts large offsets in place, which drives both saturation limits. The third runs after tracking windows have left unequal gains, which separates a correct fixed-point product and floor from a truncating one. The foreground windows use unit means that fall half-way between codes, which tells floor from truncation toward zero. A chain of tracking windows is checked against a window-by-window model, and in these windows the units differ in both mean and spread. One window overfeeds a single unit with full-scale codes, and a paused stream is fed junk and a half window, so that leaked samples would shift the next result.

// File: rtl/ume_pkg.sv
package ume_pkg;

    // What the correction registers do at the current edge
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_TRACK = 2'd1,
        UPD_LOAD  = 2'd2
    } upd_kind_e;

endpackage

// File: rtl/ume_apply.sv
module ume_apply #(
    parameter int N  = 4,
    parameter int DW = 12,
    parameter int GW = 16,
    localparam int UW = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [UW-1:0]        in_unit,
    input  logic [DW-1:0]        in_code,
    input  logic [N*DW-1:0]      ofs_flat,
    input  logic [N*GW-1:0]      gain_flat,
    output logic                 out_valid,
    output logic [UW-1:0]        out_unit,
    output logic [DW-1:0]        out_code,
    output logic [DW:0]          out_ctr
);
    localparam int PW = DW + GW + 2;
    localparam logic signed [PW-1:0] MAXV = PW'((2 ** (DW - 1)) - 1);
    localparam logic signed [PW-1:0] MINV = PW'(-(2 ** (DW - 1)));

    typedef struct packed {
        logic          valid;
        logic [UW-1:0] unit;
        logic [DW-1:0] code;
        logic [DW:0]   ctr;
    } st_t;

    st_t q, d;
    logic signed [DW-1:0] ofs_sel;
    logic        [GW-1:0] gain_sel;
    logic signed [DW:0]   centred;
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] scaled;

    always_comb begin
        ofs_sel  = $signed(ofs_flat[in_unit*DW +: DW]);
        gain_sel = gain_flat[in_unit*GW +: GW];
        centred  = (DW+1)'($signed(in_code)) - (DW+1)'(ofs_sel);
        prod     = PW'(centred) * $signed({1'b0, gain_sel});
        scaled   = prod >>> (GW - 1);
        d        = q;
        d.valid  = in_valid;
        if (in_valid) begin
            d.unit = in_unit;
            d.ctr  = centred;
            if (scaled > MAXV)      d.code = MAXV[DW-1:0];
            else if (scaled < MINV) d.code = MINV[DW-1:0];
            else                    d.code = scaled[DW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.valid;
    assign out_unit  = q.unit;
    assign out_code  = q.code;
    assign out_ctr   = q.ctr;

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_UNIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_unit == $past(in_unit))); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2

endmodule

// File: rtl/ume_stats.sv
module ume_stats #(
    parameter int N  = 4,
    parameter int DW = 12,
    parameter int KW = 4,
    localparam int UW = $clog2(N),
    localparam int CW = DW + 1 + KW,
    localparam int MW = DW + KW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            s_valid,
    input  logic [UW-1:0]   s_unit,
    input  logic [DW-1:0]   s_code,
    input  logic [DW:0]     s_ctr,
    output logic            win_done,
    output logic [N*CW-1:0] sum_ctr,
    output logic [N*MW-1:0] sum_mag
);
    localparam logic [KW:0] WIN = (KW+1)'(2 ** KW);

    typedef struct packed {
        logic [N-1:0][KW:0]   cnt;
        logic [N-1:0][CW-1:0] sc;
        logic [N-1:0][MW-1:0] sm;
        logic                 stale;
    } st_t;

    st_t q, d;
    logic          full;
    logic [DW-1:0] mag;

    always_comb begin
        full = 1'b1;
        for (int u = 0; u < N; u++) begin
            if (q.cnt[u] != WIN) full = 1'b0;
        end
        win_done = full && run;
        mag      = s_code[DW-1] ? DW'(-s_code) : s_code;
        d        = q;
        // the sample registered on an update edge was corrected with old values
        d.stale  = win_done;
        if (!run || win_done) begin
            d.cnt = '0;
            d.sc  = '0;
            d.sm  = '0;
        end else if (s_valid && !q.stale) begin
            for (int u = 0; u < N; u++) begin
                if (UW'(u) == s_unit && q.cnt[u] != WIN) begin
                    d.cnt[u] = q.cnt[u] + 1'b1;
                    d.sc[u]  = q.sc[u] + CW'($signed(s_ctr));
                    d.sm[u]  = q.sm[u] + MW'(mag);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sum_ctr = q.sc;
    assign sum_mag = q.sm;

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            AST_WIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
                q.cnt[g] <= WIN); // R4
            AST_PAUSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> (q.cnt[g] == '0)); // R8
        end
    endgenerate

endmodule

// File: rtl/ume_update.sv
module ume_update
    import ume_pkg::*;
#(
    parameter int N     = 4,
    parameter int DW    = 12,
    parameter int KW    = 4,
    parameter int GW    = 16,
    parameter int OSTEP = 1,
    parameter int GSTEP = 16,
    localparam int UW  = $clog2(N),
    localparam int CW  = DW + 1 + KW,
    localparam int MW  = DW + KW,
    localparam int AW  = DW + 1 + UW,
    localparam int MAW = DW + UW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            win_done,
    input  logic            fg_mode,
    input  logic [N*CW-1:0] sum_ctr,
    input  logic [N*MW-1:0] sum_mag,
    output logic [N*DW-1:0] ofs_flat,
    output logic [N*GW-1:0] gain_flat
);
    localparam logic signed [DW+1:0] OMAX = (DW+2)'((2 ** (DW - 1)) - 1);
    localparam logic signed [DW+1:0] OMIN = (DW+2)'(-(2 ** (DW - 1)));
    localparam logic [GW-1:0]        GONE = GW'(1) << (GW - 1);

    typedef struct packed {
        logic [N-1:0][DW-1:0] ofs;
        logic [N-1:0][GW-1:0] gain;
    } st_t;

    st_t q, d;
    upd_kind_e             kind;
    logic signed [DW:0]    mc [N];
    logic        [DW-1:0]  mm [N];
    logic signed [AW-1:0]  sum_c;
    logic        [MAW-1:0] sum_m;
    logic signed [DW:0]    avg_c;
    logic        [DW-1:0]  avg_m;
    logic signed [DW+1:0]  t;
    logic        [GW:0]    gt;

    always_comb begin
        sum_c = '0;
        sum_m = '0;
        for (int u = 0; u < N; u++) begin
            mc[u] = (DW+1)'($signed(sum_ctr[u*CW +: CW]) >>> KW);
            mm[u] = DW'(sum_mag[u*MW +: MW] >> KW);
            sum_c = sum_c + AW'(mc[u]);
            sum_m = sum_m + MAW'(mm[u]);
        end
        avg_c = (DW+1)'(sum_c >>> UW);
        avg_m = DW'(sum_m >> UW);
        kind  = !win_done ? UPD_IDLE : (fg_mode ? UPD_LOAD : UPD_TRACK);
        d     = q;
        t     = '0;
        gt    = '0;
        for (int u = 0; u < N; u++) begin
            t = (DW+2)'($signed(q.ofs[u]));
            case (kind)
                UPD_LOAD:  t = t + (DW+2)'(mc[u]);
                UPD_TRACK: begin
                    if (mc[u] > avg_c)      t = t + (DW+2)'(OSTEP);
                    else if (mc[u] < avg_c) t = t - (DW+2)'(OSTEP);
                end
                default: ;
            endcase
            if (t > OMAX)      t = OMAX;
            else if (t < OMIN) t = OMIN;
            d.ofs[u] = t[DW-1:0];
            if (kind == UPD_TRACK) begin
                if (mm[u] > avg_m) begin
                    d.gain[u] = (q.gain[u] < GW'(GSTEP)) ? '0 : q.gain[u] - GW'(GSTEP);
                end else if (mm[u] < avg_m) begin
                    gt        = {1'b0, q.gain[u]} + (GW+1)'(GSTEP);
                    d.gain[u] = gt[GW] ? '1 : gt[GW-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ofs  <= '0;
            q.gain <= {N{GONE}};
        end else begin
            q <= d;
        end
    end

    assign ofs_flat  = q.ofs;
    assign gain_flat = q.gain;

    AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !win_done |=> ($stable(q.ofs) && $stable(q.gain))); // R8
    AST_GAIN_HELD_FG: assert property (@(posedge clk) disable iff (!rst_n)
        (win_done && fg_mode) |=> $stable(q.gain)); // R7

    generate
        for (genvar g = 0; g < N; g++) begin : g_chk
            AST_OFS_SMALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (win_done && !fg_mode) |=>
                (($signed(q.ofs[g]) - $signed($past(q.ofs[g])) <= OSTEP) &&
                 ($signed(q.ofs[g]) - $signed($past(q.ofs[g])) >= -OSTEP))); // R5
            AST_GAIN_SMALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
                (win_done && !fg_mode) |=>
                ((int'(q.gain[g]) - int'($past(q.gain[g])) <= GSTEP) &&
                 (int'(q.gain[g]) - int'($past(q.gain[g])) >= -GSTEP))); // R6
        end
    endgenerate

endmodule

// File: rtl/unit_match_eq.sv
module unit_match_eq #(
    parameter int N_UNITS   = 4,
    parameter int CODE_W    = 12,
    parameter int WIN_LOG2  = 4,
    parameter int GAIN_W    = 16,
    parameter int OFS_STEP  = 1,
    parameter int GAIN_STEP = 16,
    localparam int UW = $clog2(N_UNITS),
    localparam int CW = CODE_W + 1 + WIN_LOG2,
    localparam int MW = CODE_W + WIN_LOG2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        loop_en,
    input  logic                        fg_mode,
    input  logic                        in_valid,
    input  logic [UW-1:0]               in_unit,
    input  logic [CODE_W-1:0]           in_code,
    output logic                        out_valid,
    output logic [UW-1:0]               out_unit,
    output logic [CODE_W-1:0]           out_code,
    output logic [N_UNITS*CODE_W-1:0]   ofs_corr,
    output logic [N_UNITS*GAIN_W-1:0]   gain_corr
);
    logic [CODE_W:0]          ctr;
    logic                     win_done;
    logic [N_UNITS*CW-1:0]    sum_ctr;
    logic [N_UNITS*MW-1:0]    sum_mag;

    ume_apply #(.N(N_UNITS), .DW(CODE_W), .GW(GAIN_W)) u_apply (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_unit   (in_unit),
        .in_code   (in_code),
        .ofs_flat  (ofs_corr),
        .gain_flat (gain_corr),
        .out_valid (out_valid),
        .out_unit  (out_unit),
        .out_code  (out_code),
        .out_ctr   (ctr)
    );

    ume_stats #(.N(N_UNITS), .DW(CODE_W), .KW(WIN_LOG2)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (loop_en),
        .s_valid  (out_valid),
        .s_unit   (out_unit),
        .s_code   (out_code),
        .s_ctr    (ctr),
        .win_done (win_done),
        .sum_ctr  (sum_ctr),
        .sum_mag  (sum_mag)
    );

    ume_update #(
        .N(N_UNITS), .DW(CODE_W), .KW(WIN_LOG2), .GW(GAIN_W),
        .OSTEP(OFS_STEP), .GSTEP(GAIN_STEP)
    ) u_update (
        .clk       (clk),
        .rst_n     (rst_n),
        .win_done  (win_done),
        .fg_mode   (fg_mode),
        .sum_ctr   (sum_ctr),
        .sum_mag   (sum_mag),
        .ofs_flat  (ofs_corr),
        .gain_flat (gain_corr)
    );

endmodule

// File: tb/unit_match_eq_tb.sv
`timescale 1ns/1ps
module unit_match_eq_tb;
    localparam int N  = 4;
    localparam int DW = 12;
    localparam int GW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loop_en = 1'b0;
    logic fg_mode = 1'b0;
    logic in_valid = 1'b0;
    logic [1:0] in_unit = '0;
    logic [DW-1:0] in_code = '0;
    logic out_valid;
    logic [1:0] out_unit;
    logic [DW-1:0] out_code;
    logic [N*DW-1:0] ofs_corr;
    logic [N*GW-1:0] gain_corr;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;
    int ofs_m [N];
    int gain_m [N];
    int base [N];
    int amp [N];

    always #10 clk = ~clk;

    unit_match_eq u_dut (
        .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .fg_mode(fg_mode),
        .in_valid(in_valid), .in_unit(in_unit), .in_code(in_code),
        .out_valid(out_valid), .out_unit(out_unit), .out_code(out_code),
        .ofs_corr(ofs_corr), .gain_corr(gain_corr)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rd_ofs(input int u);
        return int'($signed(ofs_corr[u*DW +: DW]));
    endfunction

    function automatic int rd_gain(input int u);
        return int'(gain_corr[u*GW +: GW]);
    endfunction

    function automatic int model_apply(input int x, input int o, input int g);
        longint p;
        p = longint'(x - o) * longint'(g);
        p = p >>> 15;
        if (p > 2047) p = 2047;
        if (p < -2048) p = -2048;
        return int'(p);
    endfunction

    function automatic int stim(input int u, input int r);
        return base[u] + (((r & 1) != 0) ? amp[u] + 1 : -amp[u]);
    endfunction

    // expected effect of one full window built from stim(u, 0..15)
    task automatic model_window(input bit fg);
        int mc [N];
        int mm [N];
        int sc, sm, y, avc, avm, t;
        avc = 0;
        avm = 0;
        for (int u = 0; u < N; u++) begin
            sc = 0;
            sm = 0;
            for (int r = 0; r < 16; r++) begin
                sc += stim(u, r) - ofs_m[u];
                y = model_apply(stim(u, r), ofs_m[u], gain_m[u]);
                sm += (y < 0) ? -y : y;
            end
            mc[u] = sc >>> 4;
            mm[u] = sm >>> 4;
            avc += mc[u];
            avm += mm[u];
        end
        avc = avc >>> 2;
        avm = avm >>> 2;
        for (int u = 0; u < N; u++) begin
            if (fg) begin
                t = ofs_m[u] + mc[u];
            end else begin
                t = ofs_m[u] + ((mc[u] > avc) ? 1 : (mc[u] < avc) ? -1 : 0);
                if (mm[u] > avm) gain_m[u] = (gain_m[u] < 16) ? 0 : gain_m[u] - 16;
                else if (mm[u] < avm) gain_m[u] = (gain_m[u] + 16 > 65535) ? 65535 : gain_m[u] + 16;
            end
            if (t > 2047) t = 2047;
            if (t < -2048) t = -2048;
            ofs_m[u] = t;
        end
    endtask

    task automatic put(input int u, input int x);
        @(negedge clk);
        in_valid = 1'b1;
        in_unit  = 2'(u);
        in_code  = DW'(x);
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic feed_window();
        for (int r = 0; r < 16; r++)
            for (int u = 0; u < N; u++) put(u, stim(u, r));
        idle(6);
    endtask

    task automatic compare_regs(input string req);
        for (int u = 0; u < N; u++) begin
            check(rd_ofs(u) == ofs_m[u], req, rd_ofs(u), ofs_m[u]);
            check(rd_gain(u) == gain_m[u], req, rd_gain(u), gain_m[u]);
        end
    endtask

    // every code through every unit with the loop paused (R2, R3)
    task automatic sweep(input string req);
        int e;
        for (int x = -2048; x < 2048; x++) begin
            for (int u = 0; u < N; u++) begin
                put(u, x);
                @(negedge clk);
                in_valid = 1'b0;
                e = model_apply(x, ofs_m[u], gain_m[u]);
                check(out_valid == 1'b1 && int'(out_unit) == u, req, int'(out_unit), u);
                check(int'($signed(out_code)) == e, req, int'($signed(out_code)), e);
            end
        end
        idle(2);
    endtask

    initial begin
        for (int u = 0; u < N; u++) begin
            ofs_m[u]  = 0;
            gain_m[u] = 32768;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        check(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
        compare_regs("R1 reset corrections");

        // R2: identity corrections
        sweep("R2 identity sweep");

        // R7: foreground load, means half-way between codes
        base = '{500, -37, -1500, 9};
        amp  = '{3, 7, 100, 0};
        loop_en = 1'b1;
        fg_mode = 1'b1;
        feed_window();
        model_window(1'b1);
        compare_regs("R7 foreground load");
        check(rd_ofs(1) == -37, "R7 floor of negative mean", rd_ofs(1), -37);
        loop_en = 1'b0;
        fg_mode = 1'b0;
        idle(2);

        // R3: large offsets push both limits
        sweep("R3 saturating sweep");

        // R5 R6: chain of tracking windows
        base = '{40, -60, 10, 200};
        amp  = '{100, 400, 50, 800};
        loop_en = 1'b1;
        for (int w = 0; w < 10; w++) begin
            feed_window();
            model_window(1'b0);
            compare_regs("R5 R6 tracking window");
        end

        // R4: unit 0 overfed with full-scale codes before the others arrive
        for (int r = 0; r < 20; r++) put(0, (r < 16) ? stim(0, r) : 2047);
        for (int r = 0; r < 16; r++)
            for (int u = 1; u < N; u++) put(u, stim(u, r));
        idle(6);
        model_window(1'b0);
        compare_regs("R4 excess samples ignored");

        // R8: paused loop fed a full window of junk
        loop_en = 1'b0;
        for (int r = 0; r < 20; r++)
            for (int u = 0; u < N; u++) put(u, 2047);
        idle(6);
        compare_regs("R8 paused hold");
        // R8: half window discarded by a pause
        loop_en = 1'b1;
        for (int r = 0; r < 8; r++)
            for (int u = 0; u < N; u++) put(u, -2048);
        idle(3);
        loop_en = 1'b0;
        idle(2);
        loop_en = 1'b1;
        idle(2);
        feed_window();
        model_window(1'b0);
        compare_regs("R8 fresh window after pause");
        loop_en = 1'b0;
        idle(2);

        // R2 with unequal gains left by tracking
        sweep("R2 scaled sweep");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule